// File: doc/BRIEF.md
# Scratchpad Write-Verify-Copy Memory Function Controller

This block is the memory-command layer of a single-wire serial EEPROM. It sits above a bit-slot engine that has already assembled bytes. Each received byte arrives with a strobe and a count of its valid bits, so a truncated last byte can be recognised. Each transmit request returns the next byte the device would send. A bus-reset input aborts whatever command is open and returns the block to command decode.

Data never goes straight into the 512-byte array. The host first fills a 32-byte scratchpad and gets an inverted CRC16 of the whole transaction back. It can then read the scratchpad together with its target address and status. Finally it commits the data with a copy command. The copy runs only if the host echoes the two target-address bytes and the ending-offset/status byte exactly. Copy time is modelled by a parameterised cycle counter, and the array is written one byte per cycle while that counter runs. A read-memory command streams array contents from any address.

Top module: `spx_memfn`

## Requirements
- R1: The first complete byte after reset or bus reset selects the command: 0Fh write scratchpad, AAh read scratchpad, 55h copy scratchpad, F0h read memory. Any other code makes the block ignore all received bytes and answer every transmit request with FFh until the next bus reset. All bytes travel LSB first.
- R2: Write scratchpad takes TA1 and then TA2. Each later complete byte is stored at scratchpad offset TA1[4:0], then the next offset upward, and the ending offset is set to the offset of the last stored byte. Bytes arriving after offset 1Fh has been filled are dropped.
- R3: When TA2 is loaded, only its least significant bit is kept and bits 7:1 read back as zero, so target addresses stay within 000h..1FFh.
- R4: The status byte has the ending offset in bits 4:0, a partial flag in bit 5, a constant 0 in bit 6 and an accepted flag in bit 7. After reset it reads 20h. Loading TA2 in a write scratchpad clears both flags and sets the ending offset to TA1[4:0]. A byte with fewer than 8 valid bits in the write data phase is discarded, sets the partial flag and closes the command.
- R5: The CRC16 (reflected x^16+x^15+x^2+1, cleared to zero) covers the command code, TA1 and TA2 as sent, and every stored data byte. During write scratchpad, if the ending offset is 1Fh, the next two transmit requests return the inverted CRC low byte and then the inverted high byte, followed by FFh. Otherwise every transmit request returns FFh.
- R6: Read scratchpad returns TA1, TA2 and the status byte, then the scratchpad bytes from offset TA1[4:0] through 1Fh, then FFh.
- R7: Copy scratchpad compares three bytes with TA1, TA2 and status, in that order. On a full match it sets the accepted flag and raises copy_busy for max(COPY_CYCLES, n+1) cycles. During that time it writes scratchpad offsets from TA1[4:0] up to the ending offset (or up to 1Fh) into array address {TA2[0], TA1[7:5], offset}.
- R8: On any mismatch nothing is copied, copy_busy stays low, the status is unchanged and the command closes, so transmit requests return FFh.
- R9: While copy_busy is high, received bytes are ignored and transmit requests return 00h.
- R10: After a copy completes, every transmit request returns AAh until a bus reset.
- R11: Read memory loads TA1 and TA2 (masked as in R3) from the next two bytes, then returns array bytes from that address upward, and FFh once past 1FFh. The status byte is left unchanged.
- R12: A bus reset returns the command decoder to its initial state in the next cycle. A copy in progress still finishes.
- R13: tx_data is a register that takes the requested byte on the clock edge where tx_req is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Bus reset pulse; ends the open command |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received byte |
| rx_bits | input | 4 | Valid bit count of the byte; 8 or more means complete |
| tx_req | input | 1 | One-cycle request for the next transmit byte |
| tx_data | output | 8 | Byte answering the latest request |
| copy_busy | output | 1 | High while a copy runs |

## Verification
Every received byte and every transmit request takes effect on the edge that samples it. Register state and tx_data are therefore due one cycle after the stimulus, and the bench drives on the falling edge and reads on the next falling edge. copy_busy is already high at the falling edge that follows the third authorization byte. The bench then counts falling edges with copy_busy high and expects exactly COPY_CYCLES, since no copy exceeds 32 bytes. Byte and read injections during that window are timed by the same count, and their absence of effect is read back through read scratchpad once the copy has finished.

// File: rtl/spx_pkg.sv
package spx_pkg;

    localparam int OFF_W = 5;

    localparam logic [7:0] CMD_WR_SP  = 8'h0F;
    localparam logic [7:0] CMD_RD_SP  = 8'hAA;
    localparam logic [7:0] CMD_CP_SP  = 8'h55;
    localparam logic [7:0] CMD_RD_MEM = 8'hF0;

    localparam logic [7:0] FILL_BYTE = 8'hFF;
    localparam logic [7:0] ALT_BYTE  = 8'hAA;
    localparam logic [7:0] BUSY_BYTE = 8'h00;

    typedef enum logic [3:0] {
        ST_CMD, ST_WS_A1, ST_WS_A2, ST_WS_DATA, ST_WS_CRC,
        ST_RS, ST_CP_A1, ST_CP_A2, ST_CP_A3, ST_COPY, ST_CP_DONE,
        ST_RM_A1, ST_RM_A2, ST_RM_DATA, ST_SINK
    } fn_state_e;

    typedef struct packed {
        logic             aa;
        logic             zero;
        logic             pf;
        logic [OFF_W-1:0] eo;
    } es_t;

    localparam es_t ES_RESET = '{aa: 1'b0, zero: 1'b0, pf: 1'b1, eo: '0};

    // reflected x^16+x^15+x^2+1, one byte LSB first
    function automatic logic [15:0] crc16_step(logic [15:0] crc, logic [7:0] d);
        logic [15:0] c;
        c = crc;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ 16'hA001;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/spx_crc16.sv
module spx_crc16 import spx_pkg::*; (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst)        crc <= '0;
        else if (start) crc <= crc16_step(16'h0000, din);
        else if (en)    crc <= crc16_step(crc, din);
    end
endmodule

// File: rtl/spx_regmem.sv
module spx_regmem #(
    parameter int AW       = 5,
    parameter int RD_PORTS = 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [AW-1:0]                 waddr,
    input  logic [7:0]                    wdata,
    input  logic [RD_PORTS-1:0][AW-1:0]   raddr,
    output logic [RD_PORTS-1:0][7:0]      rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < RD_PORTS; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end
endmodule

// File: rtl/spx_memfn.sv
module spx_memfn import spx_pkg::*; #(
    parameter int MEM_AW      = 9,
    parameter int COPY_CYCLES = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_reset,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic [3:0] rx_bits,
    input  logic       tx_req,
    output logic [7:0] tx_data,
    output logic       copy_busy
);
    localparam int HI_W  = MEM_AW - 8;
    localparam int CNT_W = $clog2(COPY_CYCLES + 1);
    localparam logic [7:0] HI_MASK = 8'((1 << HI_W) - 1);

    fn_state_e          state;
    logic [7:0]         ta1, ta2;
    es_t                es;
    logic [OFF_W:0]     wp, rptr;
    logic [1:0]         hdr_idx, crc_idx;
    logic [MEM_AW:0]    rm_ptr;
    logic               auth_bad, busy, cp_fin;
    logic [OFF_W-1:0]   cp_off;
    logic [CNT_W-1:0]   cp_cnt;

    logic               rx_full, rx_ok;
    logic [7:0]         ta2_in;
    logic               crc_start, crc_en, sp_we, arr_we;
    logic [15:0]        crc;
    logic [1:0][OFF_W-1:0] sp_raddr;
    logic [1:0][7:0]    sp_rdata;
    logic [MEM_AW-1:0]  arr_waddr;
    logic [0:0][MEM_AW-1:0] arr_raddr;
    logic [0:0][7:0]    arr_rdata;

    assign rx_full   = (rx_bits >= 4'd8);
    assign rx_ok     = rx_valid && rx_full && !busy && !bus_reset;
    assign ta2_in    = rx_byte & HI_MASK;
    assign copy_busy = busy;

    assign crc_start = rx_ok && (state == ST_CMD) && (rx_byte == CMD_WR_SP);
    assign crc_en    = rx_ok && ((state == ST_WS_A1) || (state == ST_WS_A2) ||
                                 ((state == ST_WS_DATA) && !wp[OFF_W]));
    assign sp_we     = rx_ok && (state == ST_WS_DATA) && !wp[OFF_W];
    assign sp_raddr[0] = rptr[OFF_W-1:0];
    assign sp_raddr[1] = cp_off;
    assign arr_we    = busy && !cp_fin;
    assign arr_waddr = {ta2[HI_W-1:0], ta1[7:OFF_W], cp_off};
    assign arr_raddr[0] = rm_ptr[MEM_AW-1:0];

    spx_crc16 u_crc (
        .clk(clk), .rst(rst), .start(crc_start), .en(crc_en),
        .din(rx_byte), .crc(crc)
    );

    spx_regmem #(.AW(OFF_W), .RD_PORTS(2)) u_scratch (
        .clk(clk), .rst(rst), .we(sp_we), .waddr(wp[OFF_W-1:0]),
        .wdata(rx_byte), .raddr(sp_raddr), .rdata(sp_rdata)
    );

    spx_regmem #(.AW(MEM_AW), .RD_PORTS(1)) u_array (
        .clk(clk), .rst(rst), .we(arr_we), .waddr(arr_waddr),
        .wdata(sp_rdata[1]), .raddr(arr_raddr), .rdata(arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_CMD;
            ta1      <= '0;
            ta2      <= '0;
            es       <= ES_RESET;
            wp       <= '0;
            rptr     <= '0;
            hdr_idx  <= '0;
            crc_idx  <= '0;
            rm_ptr   <= '0;
            auth_bad <= 1'b0;
            busy     <= 1'b0;
            cp_fin   <= 1'b1;
            cp_off   <= '0;
            cp_cnt   <= '0;
            tx_data  <= FILL_BYTE;
        end else begin
            // copy engine: one byte per cycle, busy held for the modelled time
            if (busy) begin
                if (cp_cnt != '0) cp_cnt <= cp_cnt - 1'b1;
                if (!cp_fin) begin
                    cp_off <= cp_off + 1'b1;
                    if ((cp_off == es.eo) || (&cp_off)) cp_fin <= 1'b1;
                end
                if ((cp_cnt == '0) && cp_fin) begin
                    busy <= 1'b0;
                    if (state == ST_COPY) state <= ST_CP_DONE;
                end
            end

            if (bus_reset) begin
                state <= ST_CMD;
            end else if (rx_valid) begin
                if (!busy) begin
                    case (state)
                        ST_CMD: if (rx_full) begin
                            case (rx_byte)
                                CMD_WR_SP:  state <= ST_WS_A1;
                                CMD_RD_SP: begin
                                    state   <= ST_RS;
                                    hdr_idx <= '0;
                                    rptr    <= {1'b0, ta1[OFF_W-1:0]};
                                end
                                CMD_CP_SP: begin
                                    state    <= ST_CP_A1;
                                    auth_bad <= 1'b0;
                                end
                                CMD_RD_MEM: state <= ST_RM_A1;
                                default:    state <= ST_SINK;
                            endcase
                        end
                        ST_WS_A1: if (rx_full) begin
                            ta1   <= rx_byte;
                            state <= ST_WS_A2;
                        end else state <= ST_SINK;
                        ST_WS_A2: if (rx_full) begin
                            ta2     <= ta2_in;
                            es      <= '{aa: 1'b0, zero: 1'b0, pf: 1'b0, eo: ta1[OFF_W-1:0]};
                            wp      <= {1'b0, ta1[OFF_W-1:0]};
                            crc_idx <= '0;
                            state   <= ST_WS_DATA;
                        end else state <= ST_SINK;
                        ST_WS_DATA: if (rx_full) begin
                            if (!wp[OFF_W]) begin
                                es.eo <= wp[OFF_W-1:0];
                                wp    <= wp + 1'b1;
                            end
                        end else begin
                            es.pf <= 1'b1;
                            state <= ST_SINK;
                        end
                        ST_CP_A1: if (rx_full) begin
                            auth_bad <= (rx_byte != ta1);
                            state    <= ST_CP_A2;
                        end else state <= ST_SINK;
                        ST_CP_A2: if (rx_full) begin
                            auth_bad <= auth_bad || (rx_byte != ta2);
                            state    <= ST_CP_A3;
                        end else state <= ST_SINK;
                        ST_CP_A3: if (rx_full && !auth_bad && (rx_byte == es)) begin
                            es.aa  <= 1'b1;
                            busy   <= 1'b1;
                            cp_fin <= 1'b0;
                            cp_off <= ta1[OFF_W-1:0];
                            cp_cnt <= CNT_W'(COPY_CYCLES - 1);
                            state  <= ST_COPY;
                        end else state <= ST_SINK;
                        ST_RM_A1: if (rx_full) begin
                            ta1   <= rx_byte;
                            state <= ST_RM_A2;
                        end else state <= ST_SINK;
                        ST_RM_A2: if (rx_full) begin
                            ta2    <= ta2_in;
                            rm_ptr <= {1'b0, ta2_in[HI_W-1:0], ta1};
                            state  <= ST_RM_DATA;
                        end else state <= ST_SINK;
                        default: ;
                    endcase
                end
            end else if (tx_req) begin
                if (busy) begin
                    tx_data <= BUSY_BYTE;
                end else begin
                    case (state)
                        ST_WS_DATA: if (es.eo == '1) begin
                            tx_data <= ~crc[7:0];
                            crc_idx <= 2'd1;
                            state   <= ST_WS_CRC;
                        end else begin
                            tx_data <= FILL_BYTE;
                            state   <= ST_SINK;
                        end
                        ST_WS_CRC: if (crc_idx == 2'd1) begin
                            tx_data <= ~crc[15:8];
                            crc_idx <= 2'd2;
                        end else tx_data <= FILL_BYTE;
                        ST_RS: begin
                            case (hdr_idx)
                                2'd0:    tx_data <= ta1;
                                2'd1:    tx_data <= ta2;
                                2'd2:    tx_data <= es;
                                default: if (!rptr[OFF_W]) begin
                                    tx_data <= sp_rdata[0];
                                    rptr    <= rptr + 1'b1;
                                end else tx_data <= FILL_BYTE;
                            endcase
                            if (hdr_idx != 2'd3) hdr_idx <= hdr_idx + 1'b1;
                        end
                        ST_RM_DATA: if (!rm_ptr[MEM_AW]) begin
                            tx_data <= arr_rdata[0];
                            rm_ptr  <= rm_ptr + 1'b1;
                        end else tx_data <= FILL_BYTE;
                        ST_CP_DONE: tx_data <= ALT_BYTE;
                        default:    tx_data <= FILL_BYTE;
                    endcase
                end
            end
        end
    end

    // R3: loaded TA2 keeps only the in-range bits
    p_ta2_mask_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_ok && state == ST_WS_A2) |=> (ta2 == ($past(rx_byte) & HI_MASK)));

    // R4: truncated data byte raises the partial flag
    p_pf_set_r4: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_full && !busy && !bus_reset && state == ST_WS_DATA) |=> es.pf);

    // R7: a copy only starts with the accepted flag set
    p_aa_on_copy_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> es.aa);

    // R8: failed authorization never starts a copy
    p_auth_fail_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_ok && state == ST_CP_A3 && (auth_bad || rx_byte != es)) |=> !busy);

    // R9: address and status registers frozen while copying
    p_busy_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(ta1) && $stable(ta2) && $stable(es)));

    // R10: finished copy answers with the alternating pattern
    p_alt_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !rx_valid && !bus_reset && !busy && state == ST_CP_DONE) |=> (tx_data == ALT_BYTE));

    // R12: bus reset returns to command decode
    p_bus_rst_r12: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (state == ST_CMD));

endmodule

// File: tb/tb_spx_memfn.sv
module tb_spx_memfn;
    localparam int COPY_CYCLES = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_reset = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic [3:0] rx_bits = 4'd8;
    logic       tx_req = 1'b0;
    logic [7:0] tx_data;
    logic       copy_busy;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [7:0] m_arr [512];
    logic [7:0] m_sp  [32];
    logic [7:0] m_ta1, m_ta2, m_es;

    spx_memfn #(.MEM_AW(9), .COPY_CYCLES(COPY_CYCLES)) dut (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_bits(rx_bits), .tx_req(tx_req),
        .tx_data(tx_data), .copy_busy(copy_busy)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL R12 watchdog: got cycle %0d expected below 150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [15:0] m_crc(logic [15:0] c, logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            logic fb;
            fb = r[0] ^ b[k];
            r  = {1'b0, r[15:1]};
            if (fb) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic [3:0] nb);
        rx_valid = 1'b1;
        rx_byte  = b;
        rx_bits  = nb;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_bits  = 4'd8;
    endtask

    task automatic get(output logic [7:0] b);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        b = tx_data;
    endtask

    task automatic breset();
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] a1, input logic [7:0] a2, input int n,
                            input bit partial);
        logic [15:0] c;
        logic [7:0]  d, b;
        int off, eo;
        breset();
        send(8'h0F, 4'd8); c = m_crc(16'h0, 8'h0F);
        send(a1, 4'd8);    c = m_crc(c, a1);
        send(a2, 4'd8);    c = m_crc(c, a2);
        m_ta1 = a1;
        m_ta2 = a2 & 8'h01;
        off = int'(a1[4:0]);
        eo  = off;
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send(d, 4'd8);
            if (off < 32) begin
                m_sp[off] = d;
                eo = off;
                off++;
                c = m_crc(c, d);
            end
        end
        if (partial) send(8'($urandom), 4'(1 + $urandom % 7));
        m_es = {1'b0, 1'b0, partial, 5'(eo)};
        get(b);
        chk("R5 crc low", b, (!partial && eo == 31) ? ~c[7:0] : 8'hFF);
        get(b);
        chk("R5 crc high", b, (!partial && eo == 31) ? ~c[15:8] : 8'hFF);
        get(b);
        chk("R5 after crc", b, 8'hFF);
    endtask

    task automatic do_read_sp();
        logic [7:0] b;
        breset();
        send(8'hAA, 4'd8);
        get(b); chk("R6 R13 TA1", b, m_ta1);
        get(b); chk("R3 TA2", b, m_ta2);
        get(b); chk("R4 status", b, m_es);
        for (int o = int'(m_ta1[4:0]); o < 32; o++) begin
            get(b); chk("R2 R6 scratch data", b, m_sp[o]);
        end
        get(b); chk("R6 fill", b, 8'hFF);
    endtask

    task automatic do_copy(input bit good, input bit disturb);
        logic [7:0] a, t, e, b;
        int cnt, o, k;
        breset();
        send(8'h55, 4'd8);
        a = m_ta1; t = m_ta2; e = m_es;
        if (!good) begin
            k = $urandom % 8;
            case ($urandom % 3)
                0:       a = a ^ (8'h01 << k);
                1:       t = t ^ (8'h01 << k);
                default: e = e ^ (8'h01 << k);
            endcase
        end
        send(a, 4'd8);
        send(t, 4'd8);
        send(e, 4'd8);
        if (good) begin
            chk("R7 busy raised", {7'b0, copy_busy}, 8'h01);
            o = int'(m_ta1[4:0]);
            forever begin
                m_arr[{m_ta2[0], m_ta1[7:5], 5'(o)}] = m_sp[o];
                if (o == int'(m_es[4:0]) || o == 31) break;
                o++;
            end
            m_es[7] = 1'b1;
            cnt = 0;
            while (copy_busy && cnt < 1000) begin
                cnt++;
                if (disturb && cnt == 2) begin
                    rx_valid = 1'b1; rx_byte = 8'h0F;
                end else if (disturb && cnt == 3) begin
                    rx_valid = 1'b1; rx_byte = 8'($urandom);
                end else rx_valid = 1'b0;
                tx_req = disturb && (cnt == 5);
                @(negedge clk);
                if (disturb && cnt == 5) chk("R9 read while busy", tx_data, 8'h00);
            end
            rx_valid = 1'b0;
            tx_req   = 1'b0;
            chk("R7 busy length", 8'(cnt), 8'(COPY_CYCLES));
            get(b); chk("R10 alt pattern", b, 8'hAA);
            get(b); chk("R10 alt pattern again", b, 8'hAA);
        end else begin
            chk("R8 no busy", {7'b0, copy_busy}, 8'h00);
            get(b); chk("R8 closed", b, 8'hFF);
        end
    endtask

    task automatic do_read_mem(input logic [8:0] addr, input int n);
        logic [7:0] b, hi;
        int p;
        breset();
        send(8'hF0, 4'd8);
        send(addr[7:0], 4'd8);
        hi = {7'($urandom), addr[8]};
        send(hi, 4'd8);
        m_ta1 = addr[7:0];
        m_ta2 = {7'b0, addr[8]};
        for (int i = 0; i < n; i++) begin
            p = int'(addr) + i;
            get(b);
            chk("R11 memory data", b, (p < 512) ? m_arr[p] : 8'hFF);
        end
    endtask

    initial begin
        logic [7:0] b;
        void'($urandom(32'd4242));
        for (int i = 0; i < 512; i++) m_arr[i] = 8'h00;
        for (int i = 0; i < 32; i++)  m_sp[i]  = 8'h00;
        m_ta1 = 8'h00; m_ta2 = 8'h00; m_es = 8'h20;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk("R4 reset busy", {7'b0, copy_busy}, 8'h00);
        do_read_sp();

        // full page with CRC, then copy with disturbance
        do_write(8'h00, 8'h00, 32, 1'b0);
        do_read_sp();
        do_copy(1'b1, 1'b1);
        do_read_sp();
        do_read_mem(9'h000, 34);

        // short tail write, TA2 masking, copy, read past end of array
        do_write(8'h3C, 8'hFF, 6, 1'b0);
        do_read_sp();
        do_copy(1'b1, 1'b0);
        do_read_mem(9'h1F0, 20);
        do_read_sp();

        // truncated byte, then a rejected copy
        do_write(8'h45, 8'h00, 3, 1'b1);
        do_read_sp();
        do_copy(1'b0, 1'b0);
        do_read_sp();

        // unknown command: later bytes ignored
        breset();
        send(8'h3C, 4'd8);
        get(b); chk("R1 unknown fill", b, 8'hFF);
        send(8'h0F, 4'd8);
        send(8'h12, 4'd8);
        send(8'h01, 4'd8);
        get(b); chk("R1 still ignoring", b, 8'hFF);
        do_read_sp();

        // bus reset restarts an open read
        breset();
        send(8'hAA, 4'd8);
        get(b); chk("R12 first header", b, m_ta1);
        get(b);
        breset();
        send(8'hAA, 4'd8);
        get(b); chk("R12 restarted header", b, m_ta1);

        // random mix
        for (int it = 0; it < 30; it++) begin
            do_write(8'($urandom), 8'($urandom), $urandom % 37, ($urandom % 6) == 0);
            do_read_sp();
            do_copy(($urandom % 4) != 0, $urandom % 2);
            if (it % 3 == 0) begin
                do_read_mem(9'($urandom), 12);
                do_read_sp();
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule